// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block holds one word-sized reservation for a core's exclusive load and exclusive store. An exclusive load records the address and marks the reservation valid. The reservation is lost when any of the following occurs:
- an ordinary store to that word is seen on the snoop port, whether it comes from this core or from another master;
- a soft reset, interrupt, exception or break strobe arrives;
- any exclusive store is issued.

An exclusive store may go to memory only while the reservation is valid and covers the same word. In that case the block raises the memory write-enable in the same cycle. The interconnect's response for that write, presented in the same cycle, decides the final outcome. One cycle after every exclusive store, the block writes the carry flag: 0 means the store succeeded, 1 means it failed.

Address translation faults are seen only as an exception strobe. Because that strobe clears the reservation, a store-exclusive that takes a translation miss always fails.

Top module: `excl_resv_mon`

## Requirements
- R1: After an exclusive load, an exclusive store to the same word with response EXOKAY (2'b01) raises mem_we_o in its own cycle, passes its address and data through, and one cycle later pulses carry_we_o with carry_o = 0.
- R2: Address matching ignores the low GRAN_LSB (2) bits. An exclusive store to a different word fails.
- R3: An exclusive store with no valid reservation keeps mem_we_o low and writes carry_o = 1.
- R4: A snooped ordinary store to any byte of the reserved word clears the reservation. A snooped store to another word leaves the reservation intact.
- R5: A snooped store to the reserved word in the same cycle as the exclusive store makes that store fail with mem_we_o low.
- R6: Any response other than EXOKAY (OKAY 2'b00, SLVERR 2'b10, DECERR 2'b11) makes the store fail with carry_o = 1, even though mem_we_o was raised.
- R7: Each of the soft reset, interrupt, exception and break strobes clears the reservation. Any of them in the same cycle as the exclusive store makes it fail with mem_we_o low.
- R8: Every exclusive store, whether it succeeds or fails, leaves the reservation invalid.
- R9: A new exclusive load replaces the reserved address.
- R10: A clearing strobe or a same-word snoop in the same cycle as an exclusive load leaves the reservation invalid.
- R11: While rst_ni is low, the reservation is invalid and carry_o, carry_we_o and mem_we_o are 0.
- R12: carry_we_o is high for exactly the one cycle after each exclusive store. carry_o holds its value between exclusive stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ldx_valid_i | input | 1 | Exclusive load strobe |
| ldx_addr_i | input | ADDR_W | Exclusive load address |
| stx_valid_i | input | 1 | Exclusive store strobe |
| stx_addr_i | input | ADDR_W | Exclusive store address |
| stx_data_i | input | DATA_W | Exclusive store data |
| rsp_code_i | input | 2 | Interconnect response for the exclusive store |
| snoop_valid_i | input | 1 | Ordinary store seen on the bus |
| snoop_addr_i | input | ADDR_W | Address of the snooped store |
| ev_rst_i | input | 1 | Soft reset strobe |
| ev_irq_i | input | 1 | Interrupt taken strobe |
| ev_exc_i | input | 1 | Exception taken strobe |
| ev_brk_i | input | 1 | Break strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_data_o | output | DATA_W | Memory write data |
| carry_we_o | output | 1 | Carry flag write strobe |
| carry_o | output | 1 | Carry flag value, 1 on failure |

## Verification
The hardest cases are the same-cycle races, because the reservation is not visible at the ports. A snooped store or a clearing strobe can land in the same cycle as the exclusive store, or in the same cycle as the exclusive load. Each directed task therefore drives the competing strobe and the exclusive operation together in one cycle vector. It then reads the reservation's state back through a later exclusive store, whose write-enable and carry flag reveal whether the reservation survived.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    RSP_OKAY   = 2'b00,
    RSP_EXOKAY = 2'b01,
    RSP_SLVERR = 2'b10,
    RSP_DECERR = 2'b11
  } xrsp_e;
endpackage

// File: rtl/excl_word_cmp.sv
module excl_word_cmp #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic [ADDR_W-1:0] a_i,
  input  logic [ADDR_W-1:0] b_i,
  output logic              eq_o
);
  logic [ADDR_W-1:0] diff;
  assign diff = (a_i ^ b_i) >> GRAN_LSB;
  assign eq_o = (diff == '0);
endmodule

// File: rtl/excl_resv_reg.sv
module excl_resv_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  // set is pre-gated by the caller against the strobes that must win
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      addr_o  <= set_addr_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end

  a_r9_set_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (valid_o && addr_o == $past(set_addr_i)));
  a_r4_clr_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !valid_o);
endmodule

// File: rtl/excl_stx_ctrl.sv
module excl_stx_ctrl
  import excl_mon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stx_valid_i,
  input  logic       resv_hit_i,
  input  logic       kill_i,
  input  logic [1:0] rsp_code_i,
  output logic       mem_we_o,
  output logic       carry_we_o,
  output logic       carry_o
);
  logic ok;

  assign mem_we_o = stx_valid_i && resv_hit_i && !kill_i;
  assign ok       = mem_we_o && (xrsp_e'(rsp_code_i) == RSP_EXOKAY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_we_o <= 1'b0;
      carry_o    <= 1'b0;
    end else begin
      carry_we_o <= stx_valid_i;
      if (stx_valid_i) carry_o <= !ok;
    end
  end

  a_r3_no_write_without_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> resv_hit_i);
  a_r12_carry_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stx_valid_i |=> carry_we_o);
  a_r12_carry_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stx_valid_i |=> $stable(carry_o));
  a_r1_success_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_we_o && !carry_o) |-> $past(mem_we_o));
endmodule

// File: rtl/excl_resv_mon.sv
module excl_resv_mon
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ldx_valid_i,
  input  logic [ADDR_W-1:0] ldx_addr_i,
  input  logic              stx_valid_i,
  input  logic [ADDR_W-1:0] stx_addr_i,
  input  logic [DATA_W-1:0] stx_data_i,
  input  logic [1:0]        rsp_code_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              ev_rst_i,
  input  logic              ev_irq_i,
  input  logic              ev_exc_i,
  input  logic              ev_brk_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              carry_we_o,
  output logic              carry_o
);
  localparam int NCMP = 3;  // snoop vs resv, snoop vs ldx, stx vs resv

  logic              resv_valid;
  logic [ADDR_W-1:0] resv_addr;
  logic              any_event;
  logic [NCMP-1:0]   cmp_eq;
  logic [ADDR_W-1:0] cmp_a [NCMP];
  logic [ADDR_W-1:0] cmp_b [NCMP];
  logic              snp_hit_resv, snp_hit_ld, stx_hit;
  logic              resv_set, resv_clr, stx_kill;

  assign cmp_a[0] = snoop_addr_i; assign cmp_b[0] = resv_addr;
  assign cmp_a[1] = snoop_addr_i; assign cmp_b[1] = ldx_addr_i;
  assign cmp_a[2] = stx_addr_i;   assign cmp_b[2] = resv_addr;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    excl_word_cmp #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_cmp (
      .a_i (cmp_a[g]),
      .b_i (cmp_b[g]),
      .eq_o(cmp_eq[g])
    );
  end

  assign any_event    = ev_rst_i | ev_irq_i | ev_exc_i | ev_brk_i;
  assign snp_hit_resv = snoop_valid_i && resv_valid && cmp_eq[0];
  assign snp_hit_ld   = snoop_valid_i && ldx_valid_i && cmp_eq[1];
  assign stx_hit      = resv_valid && cmp_eq[2];

  // strobes, exclusive stores and a racing snoop all beat a new load
  assign resv_set = ldx_valid_i && !any_event && !stx_valid_i && !snp_hit_ld;
  assign resv_clr = any_event || stx_valid_i || snp_hit_resv || snp_hit_ld;
  assign stx_kill = any_event || snp_hit_resv;

  excl_resv_reg #(.ADDR_W(ADDR_W)) u_resv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (resv_set),
    .set_addr_i(ldx_addr_i),
    .clr_i     (resv_clr),
    .valid_o   (resv_valid),
    .addr_o    (resv_addr)
  );

  excl_stx_ctrl u_stx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stx_valid_i(stx_valid_i),
    .resv_hit_i (stx_hit),
    .kill_i     (stx_kill),
    .rsp_code_i (rsp_code_i),
    .mem_we_o   (mem_we_o),
    .carry_we_o (carry_we_o),
    .carry_o    (carry_o)
  );

  assign mem_addr_o = stx_addr_i;
  assign mem_data_o = stx_data_i;

  a_r7_event_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_event |=> !resv_valid);
  a_r8_stx_consumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stx_valid_i |=> !resv_valid);
  a_r7_event_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_event |-> !mem_we_o);
  a_r5_snoop_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_hit_resv |-> !mem_we_o);
endmodule

// File: tb/excl_resv_mon_tb.sv
`timescale 1ns/1ps
module excl_resv_mon_tb;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [1:0] OKAY = 2'b00, EXOK = 2'b01, SLVE = 2'b10, DECE = 2'b11;

  logic clk = 0, rst_n = 0;
  logic ldx_v = 0, stx_v = 0, snp_v = 0;
  logic [AW-1:0] ldx_a = '0, stx_a = '0, snp_a = '0;
  logic [DW-1:0] stx_d = '0;
  logic [1:0] rsp = 2'b00;
  logic [3:0] ev = '0;  // {brk, exc, irq, rst}
  logic mem_we, carry_we, carry;
  logic [AW-1:0] mem_a;
  logic [DW-1:0] mem_d;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  excl_resv_mon u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ldx_valid_i(ldx_v), .ldx_addr_i(ldx_a),
    .stx_valid_i(stx_v), .stx_addr_i(stx_a), .stx_data_i(stx_d),
    .rsp_code_i(rsp), .snoop_valid_i(snp_v), .snoop_addr_i(snp_a),
    .ev_rst_i(ev[0]), .ev_irq_i(ev[1]), .ev_exc_i(ev[2]), .ev_brk_i(ev[3]),
    .mem_we_o(mem_we), .mem_addr_o(mem_a), .mem_data_o(mem_d),
    .carry_we_o(carry_we), .carry_o(carry)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ldx_v = 0; stx_v = 0; snp_v = 0; ev = '0; rsp = OKAY;
  endtask

  // one cycle of a load-exclusive, optionally with a racing snoop/strobe
  task automatic ldx(logic [AW-1:0] a, logic sv = 0, logic [AW-1:0] sa = '0,
                     logic [3:0] e = '0);
    @(negedge clk);
    ldx_v = 1; ldx_a = a; snp_v = sv; snp_a = sa; ev = e;
    @(negedge clk);
    idle();
  endtask

  task automatic snoop(logic [AW-1:0] a);
    @(negedge clk); snp_v = 1; snp_a = a;
    @(negedge clk); idle();
  endtask

  task automatic strobe(logic [3:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); idle();
  endtask

  // exclusive store; checks write-enable now and the carry one cycle later
  task automatic stx(logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] r,
                     bit exp_we, bit exp_c, string tag,
                     logic sv = 0, logic [AW-1:0] sa = '0, logic [3:0] e = '0);
    @(negedge clk);
    stx_v = 1; stx_a = a; stx_d = d; rsp = r; snp_v = sv; snp_a = sa; ev = e;
    #1;
    chk(mem_we == exp_we, {tag, " we"}, 64'(mem_we), 64'(exp_we));
    if (exp_we) begin
      chk(mem_a == a, {tag, " addr"}, 64'(mem_a), 64'(a));
      chk(mem_d == d, {tag, " data"}, 64'(mem_d), 64'(d));
    end
    @(negedge clk);
    idle();
    chk(carry_we == 1'b1, {tag, " R12 carry_we"}, 64'(carry_we), 64'd1);
    chk(carry == exp_c, {tag, " carry"}, 64'(carry), 64'(exp_c));
  endtask

  task automatic t_reset();
    chk(carry == 0 && carry_we == 0 && mem_we == 0, "R11 reset outputs",
        {61'd0, carry, carry_we, mem_we}, 64'd0);
    rst_n = 1;
    stx(32'h40, 32'h1, EXOK, 0, 1, "R3 no reservation");
  endtask

  task automatic t_basic();
    ldx(32'h100);
    stx(32'h100, 32'hCAFE_0001, EXOK, 1, 0, "R1 success");
    @(negedge clk);
    chk(carry_we == 0, "R12 single pulse", 64'(carry_we), 64'd0);
    chk(carry == 0, "R12 hold 0", 64'(carry), 64'd0);
  endtask

  task automatic t_gran();
    ldx(32'h203);
    stx(32'h200, 32'h2, EXOK, 1, 0, "R2 same word");
    ldx(32'h200);
    stx(32'h204, 32'h3, EXOK, 0, 1, "R2 other word");
  endtask

  task automatic t_consume();
    ldx(32'h180);
    stx(32'h180, 32'h4, EXOK, 1, 0, "R8 first");
    stx(32'h180, 32'h5, EXOK, 0, 1, "R8 after success");
    ldx(32'h180);
    stx(32'h184, 32'h6, EXOK, 0, 1, "R8 failing");
    stx(32'h180, 32'h7, EXOK, 0, 1, "R8 after failure");
  endtask

  task automatic t_snoop();
    ldx(32'h300);
    snoop(32'h302);
    stx(32'h300, 32'h8, EXOK, 0, 1, "R4 snoop same word");
    ldx(32'h300);
    snoop(32'h400);
    stx(32'h300, 32'h9, EXOK, 1, 0, "R4 snoop other word");
  endtask

  task automatic t_snoop_race();
    ldx(32'h500);
    stx(32'h500, 32'hA, EXOK, 0, 1, "R5 same-cycle snoop", 1, 32'h501);
    ldx(32'h500);
    stx(32'h500, 32'hB, EXOK, 1, 0, "R5 same-cycle snoop elsewhere", 1, 32'h600);
  endtask

  task automatic t_rsp();
    ldx(32'h700);
    stx(32'h700, 32'hC, OKAY, 1, 1, "R6 OKAY");
    ldx(32'h700);
    stx(32'h700, 32'hD, SLVE, 1, 1, "R6 SLVERR");
    ldx(32'h700);
    stx(32'h700, 32'hE, DECE, 1, 1, "R6 DECERR");
    repeat (2) @(negedge clk);
    chk(carry == 1, "R12 hold 1", 64'(carry), 64'd1);
  endtask

  task automatic t_events();
    for (int i = 0; i < 4; i++) begin
      ldx(32'h800);
      strobe(4'(1 << i));
      stx(32'h800, 32'hF, EXOK, 0, 1, $sformatf("R7 strobe %0d clears", i));
    end
    ldx(32'h800);
    stx(32'h800, 32'h10, EXOK, 0, 1, "R7 exc with stx", 0, '0, 4'b0100);
  endtask

  task automatic t_replace();
    ldx(32'h900); ldx(32'hA00);
    stx(32'h900, 32'h11, EXOK, 0, 1, "R9 old address");
    ldx(32'h900); ldx(32'hA00);
    stx(32'hA00, 32'h12, EXOK, 1, 0, "R9 new address");
  endtask

  task automatic t_race();
    ldx(32'hB00, 0, '0, 4'b0010);
    stx(32'hB00, 32'h13, EXOK, 0, 1, "R10 irq with ldx");
    ldx(32'hB00, 1, 32'hB02);
    stx(32'hB00, 32'h14, EXOK, 0, 1, "R10 snoop with ldx");
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_gran();
    t_consume();
    t_snoop();
    t_snoop_race();
    t_rsp();
    t_events();
    t_replace();
    t_race();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule